// File: doc/BRIEF.md
# Endpoint-Zero Control Transfer Sequencer

This block steers the default control pipe of a low-speed serial bus device through the three phases of each control transfer. It gathers the eight request bytes that follow a SETUP token and reads the direction bit and the length field from them. It then runs the data phase in packets of at most `MAX_PKT` bytes. It ends with a zero-length handshake packet that travels the other way. While the transfer runs, it tracks how many bytes remain and where the next packet sits in the descriptor store.

A handshake responder reports each finished transaction to the block: the token kind and the number of bytes received. In return, the block issues one-cycle arm pulses for transmit and receive, the byte count for the next transmit packet, and the current buffer address. It also holds a stall level. An outside request decoder watches the same request bytes. When the SETUP completes, it answers with a hit flag, a descriptor base and a descriptor size. A device address assigned by the host is kept back and written to the address register only once the handshake phase has finished, because that phase still runs at the old address.

Top module: `ep0_ctl_seq`

## Requirements
- R1: The eight request bytes arrive in order: type, code, value low, value high, index low, index high, length low, length high. A SETUP completion whose byte count is not 8 stalls the endpoint.
- R2: A supported request with length 0 goes straight to the status-in stage (stage code 3), with a transmit arm pulse and a transmit count of 0 in the following cycle.
- R3: Bit 7 of the type byte sets the data direction: 1 enters the data-in stage (code 1) with its first packet armed, and 0 enters the data-out stage (code 2).
- R4: For a device-to-host request, the remaining count starts at the smaller of the requested length and the descriptor size. Every transmit count is the smaller of the remaining count and `MAX_PKT`.
- R5: After each acknowledged IN packet, the remaining count drops by the bytes sent and `buf_addr` advances by the same amount. The next packet is then armed.
- R6: When the remaining count of a control read reaches zero (a 0-byte read sends one empty packet), the stage becomes status-out (code 4) and `status_out_pend` rises. A zero-length OUT then returns the block to idle (code 0) and clears the flag.
- R7: An OUT carrying data while `status_out_pend` is set stalls the endpoint and clears the flag.
- R8: In a control write, each OUT advances `buf_addr` by its byte count. When the remaining count reaches zero, or a packet shorter than `MAX_PKT` arrives, the block enters status-in and arms a zero-length transmit.
- R9: A request with type 0x00, code 0x05 and length 0 carries a new address in the low 7 bits of its value. `addr_we` pulses with that address only in the cycle after the status-in IN is acknowledged, and never before it.
- R10: `rx_arm` pulses in the cycle after every SETUP or OUT completion, in every stage, so a new SETUP can always be received.
- R11: An unsupported request (`desc_hit` low), an IN or OUT in a stage that does not expect it, or an OUT larger than the remaining count raises `ep_stall` and enters the stall stage (code 5). IN and OUT leave that state unchanged, and the next valid SETUP clears it.
- R12: After reset the stage is idle, no stall is raised, no pulse is active, and `tx_count` and `buf_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_byte_vld | input | 1 | One request byte is present |
| setup_byte | input | 8 | Request byte value |
| xact_vld | input | 1 | Transaction completed this cycle |
| xact_tok | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| xact_len | input | CW | Bytes received in the completed transaction |
| desc_hit | input | 1 | Request is supported (sampled with a SETUP completion) |
| desc_base | input | ADDR_W | Descriptor or receive buffer start address |
| desc_size | input | LEN_W | Descriptor size in bytes |
| tx_arm | output | 1 | One-cycle pulse: arm the transmit side |
| rx_arm | output | 1 | One-cycle pulse: re-arm reception |
| ep_stall | output | 1 | Endpoint stalled |
| tx_count | output | CW | Byte count of the armed transmit packet |
| buf_addr | output | ADDR_W | Current buffer address |
| status_out_pend | output | 1 | Expecting the zero-length status OUT |
| addr_we | output | 1 | One-cycle device address write strobe |
| addr_val | output | 7 | Device address to write |
| ctl_stage | output | 3 | Current stage code |

## Verification
The bench builds the block with its defaults: 8-byte packets, 16-bit lengths and 10-bit addresses. With these values a sweep of requested lengths from 1 to 36, run against descriptor sizes of 0, 5, 8, 16 and 34, covers several cases. These are exact multiples of the packet size, one-byte tails, truncation by a short descriptor, and the empty read that sends one zero-length packet. All of these finish within a few cycles each. Control writes are swept over lengths from 1 to 24. Set-address is swept over the 7-bit address range, and every stall path is driven on purpose.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  localparam int SETUP_BYTES = 8;
  localparam int DEV_ADDR_W  = 7;
  localparam logic [7:0] SETADDR_TYPE = 8'h00;
  localparam logic [7:0] SETADDR_CODE = 8'h05;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2
  } ctl_tok_e;

  typedef enum logic [2:0] {
    STG_IDLE     = 3'd0,
    STG_DATA_IN  = 3'd1,
    STG_DATA_OUT = 3'd2,
    STG_STAT_IN  = 3'd3,
    STG_STAT_OUT = 3'd4,
    STG_STALL    = 3'd5
  } ctl_stage_e;

  typedef struct packed {
    logic [7:0]  rtype;
    logic [7:0]  code;
    logic [15:0] value;
    logic [15:0] index;
    logic [15:0] length;
  } ctl_req_t;
endpackage

// File: rtl/ctl_setup_capture.sv
module ctl_setup_capture
  import ctl_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       restart,
  output ctl_req_t   req
);
  localparam int IW = $clog2(SETUP_BYTES);

  logic [7:0]    bytes_q [SETUP_BYTES];
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (restart) begin
      idx_q <= '0;
    end else if (byte_vld) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < SETUP_BYTES; g++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) begin
          bytes_q[g] <= '0;
        end else if (byte_vld && !restart && idx_q == IW'(g)) begin
          bytes_q[g] <= byte_in;
        end
      end
    end
  endgenerate

  always_comb begin
    req.rtype  = bytes_q[0];
    req.code   = bytes_q[1];
    req.value  = {bytes_q[3], bytes_q[2]};
    req.index  = {bytes_q[5], bytes_q[4]};
    req.length = {bytes_q[7], bytes_q[6]};
  end
endmodule

// File: rtl/ctl_xfer_track.sv
module ctl_xfer_track #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LEN_W-1:0]  load_rem,
  input  logic [ADDR_W-1:0] load_ptr,
  input  logic              step,
  input  logic [LEN_W-1:0]  step_amt,
  output logic [LEN_W-1:0]  rem,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      ptr <= '0;
    end else if (load) begin
      rem <= load_rem;
      ptr <= load_ptr;
    end else if (step) begin
      rem <= rem - step_amt;
      ptr <= ptr + ADDR_W'(step_amt);
    end
  end
endmodule

// File: rtl/ep0_ctl_seq.sv
module ep0_ctl_seq
  import ctl_seq_pkg::*;
#(
  parameter int MAX_PKT = 8,
  parameter int LEN_W   = 16,
  parameter int ADDR_W  = 10,
  localparam int CW     = $clog2(MAX_PKT + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  setup_byte_vld,
  input  logic [7:0]            setup_byte,
  input  logic                  xact_vld,
  input  logic [1:0]            xact_tok,
  input  logic [CW-1:0]         xact_len,
  input  logic                  desc_hit,
  input  logic [ADDR_W-1:0]     desc_base,
  input  logic [LEN_W-1:0]      desc_size,
  output logic                  tx_arm,
  output logic                  rx_arm,
  output logic                  ep_stall,
  output logic [CW-1:0]         tx_count,
  output logic [ADDR_W-1:0]     buf_addr,
  output logic                  status_out_pend,
  output logic                  addr_we,
  output logic [DEV_ADDR_W-1:0] addr_val,
  output logic [2:0]            ctl_stage
);
  localparam logic [LEN_W-1:0] PKT_L = LEN_W'(MAX_PKT);

  ctl_req_t   req;
  ctl_tok_e   tok;
  ctl_stage_e stage_q, stage_d;

  logic [LEN_W-1:0]      rem;
  logic [ADDR_W-1:0]     ptr;
  logic                  trk_load, trk_step;
  logic [LEN_W-1:0]      trk_rem, trk_amt;
  logic                  stall_d, sflag_d, pend_d, pend_q;
  logic [DEV_ADDR_W-1:0] pend_addr_d, pend_addr_q;
  logic                  tx_arm_d, rx_arm_d, addr_we_d;
  logic [CW-1:0]         tx_count_d;
  logic [DEV_ADDR_W-1:0] addr_val_d;

  logic [LEN_W-1:0] rcv, sent, rem_after_in, rem_after_out, lim;
  logic             is_setaddr;

  assign tok = ctl_tok_e'(xact_tok);

  ctl_setup_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .byte_vld (setup_byte_vld),
    .byte_in  (setup_byte),
    .restart  (xact_vld),
    .req      (req)
  );

  ctl_xfer_track #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .load     (trk_load),
    .load_rem (trk_rem),
    .load_ptr (desc_base),
    .step     (trk_step),
    .step_amt (trk_amt),
    .rem      (rem),
    .ptr      (ptr)
  );

  function automatic logic [CW-1:0] chunk(input logic [LEN_W-1:0] v);
    return (v > PKT_L) ? CW'(MAX_PKT) : CW'(v);
  endfunction

  assign rcv           = LEN_W'(xact_len);
  assign sent          = LEN_W'(tx_count);
  assign rem_after_in  = rem - sent;
  assign rem_after_out = rem - rcv;
  assign lim           = (req.length < desc_size) ? req.length : desc_size;
  assign is_setaddr    = (req.rtype == SETADDR_TYPE) && (req.code == SETADDR_CODE);

  always_comb begin
    stage_d     = stage_q;
    stall_d     = ep_stall;
    sflag_d     = status_out_pend;
    pend_d      = pend_q;
    pend_addr_d = pend_addr_q;
    tx_arm_d    = 1'b0;
    rx_arm_d    = 1'b0;
    addr_we_d   = 1'b0;
    addr_val_d  = addr_val;
    tx_count_d  = tx_count;
    trk_load    = 1'b0;
    trk_rem     = '0;
    trk_step    = 1'b0;
    trk_amt     = '0;

    if (xact_vld) begin
      unique case (tok)
        TOK_SETUP: begin
          rx_arm_d = 1'b1;
          stall_d  = 1'b0;
          sflag_d  = 1'b0;
          pend_d   = 1'b0;
          if (xact_len != CW'(SETUP_BYTES)) begin
            stage_d = STG_STALL;
            stall_d = 1'b1;
          end else if (is_setaddr) begin
            if (req.length == '0) begin
              pend_d      = 1'b1;
              pend_addr_d = req.value[DEV_ADDR_W-1:0];
              stage_d     = STG_STAT_IN;
              tx_arm_d    = 1'b1;
              tx_count_d  = '0;
            end else begin
              stage_d = STG_STALL;
              stall_d = 1'b1;
            end
          end else if (!desc_hit) begin
            stage_d = STG_STALL;
            stall_d = 1'b1;
          end else if (req.length == '0) begin
            stage_d    = STG_STAT_IN;
            tx_arm_d   = 1'b1;
            tx_count_d = '0;
          end else if (req.rtype[7]) begin
            trk_load   = 1'b1;
            trk_rem    = lim;
            tx_count_d = chunk(lim);
            tx_arm_d   = 1'b1;
            stage_d    = STG_DATA_IN;
          end else begin
            trk_load = 1'b1;
            trk_rem  = req.length;
            stage_d  = STG_DATA_OUT;
          end
        end
        TOK_IN: begin
          unique case (stage_q)
            STG_DATA_IN: begin
              trk_step = 1'b1;
              trk_amt  = sent;
              if (rem_after_in == '0) begin
                stage_d = STG_STAT_OUT;
                sflag_d = 1'b1;
              end else begin
                tx_arm_d   = 1'b1;
                tx_count_d = chunk(rem_after_in);
              end
            end
            STG_STAT_IN: begin
              stage_d = STG_IDLE;
              if (pend_q) begin
                addr_we_d  = 1'b1;
                addr_val_d = pend_addr_q;
                pend_d     = 1'b0;
              end
            end
            STG_STALL: ;
            default: begin
              stage_d = STG_STALL;
              stall_d = 1'b1;
              sflag_d = 1'b0;
              pend_d  = 1'b0;
            end
          endcase
        end
        TOK_OUT: begin
          rx_arm_d = 1'b1;
          unique case (stage_q)
            STG_DATA_OUT: begin
              if (rcv > rem || rcv > PKT_L) begin
                stage_d = STG_STALL;
                stall_d = 1'b1;
              end else begin
                trk_step = 1'b1;
                trk_amt  = rcv;
                if (rem_after_out == '0 || rcv < PKT_L) begin
                  stage_d    = STG_STAT_IN;
                  tx_arm_d   = 1'b1;
                  tx_count_d = '0;
                end
              end
            end
            STG_STAT_OUT: begin
              sflag_d = 1'b0;
              if (rcv == '0) begin
                stage_d = STG_IDLE;
              end else begin
                stage_d = STG_STALL;
                stall_d = 1'b1;
              end
            end
            STG_STALL: ;
            default: begin
              stage_d = STG_STALL;
              stall_d = 1'b1;
              sflag_d = 1'b0;
              pend_d  = 1'b0;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q         <= STG_IDLE;
      ep_stall        <= 1'b0;
      status_out_pend <= 1'b0;
      pend_q          <= 1'b0;
      pend_addr_q     <= '0;
      tx_arm          <= 1'b0;
      rx_arm          <= 1'b0;
      addr_we         <= 1'b0;
      addr_val        <= '0;
      tx_count        <= '0;
    end else begin
      stage_q         <= stage_d;
      ep_stall        <= stall_d;
      status_out_pend <= sflag_d;
      pend_q          <= pend_d;
      pend_addr_q     <= pend_addr_d;
      tx_arm          <= tx_arm_d;
      rx_arm          <= rx_arm_d;
      addr_we         <= addr_we_d;
      addr_val        <= addr_val_d;
      tx_count        <= tx_count_d;
    end
  end

  assign buf_addr  = ptr;
  assign ctl_stage = stage_q;
endmodule

// File: rtl/ep0_ctl_seq_chk.sv
module ep0_ctl_seq_chk #(
  parameter int MAX_PKT = 8,
  parameter int ADDR_W  = 10,
  parameter int CW      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              xact_vld,
  input logic [1:0]        xact_tok,
  input logic              tx_arm,
  input logic              rx_arm,
  input logic              ep_stall,
  input logic [CW-1:0]     tx_count,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              status_out_pend,
  input logic              addr_we,
  input logic [2:0]        ctl_stage
);
  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    tx_count <= CW'(MAX_PKT));

  p_addr_after_status_r9: assert property (@(posedge clk) disable iff (rst)
    addr_we |-> ($past(ctl_stage) == 3'd3 && $past(xact_vld) && $past(xact_tok) == 2'd1));

  p_rearm_cause_r10: assert property (@(posedge clk) disable iff (rst)
    rx_arm |-> ($past(xact_vld) && $past(xact_tok) != 2'd1));

  p_stall_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(ep_stall) |-> $past(xact_vld));

  p_flag_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_out_pend) |-> ($past(xact_vld) && $past(xact_tok) == 2'd1));

  p_status_zlp_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_arm && ctl_stage == 3'd3) |-> tx_count == '0);

  p_addr_moves_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(xact_vld) |-> $stable(buf_addr));

  p_arm_stage_r3: assert property (@(posedge clk) disable iff (rst)
    tx_arm |-> (ctl_stage == 3'd1 || ctl_stage == 3'd3));
endmodule

bind ep0_ctl_seq ep0_ctl_seq_chk #(.MAX_PKT(MAX_PKT), .ADDR_W(ADDR_W), .CW(CW)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .xact_vld        (xact_vld),
  .xact_tok        (xact_tok),
  .tx_arm          (tx_arm),
  .rx_arm          (rx_arm),
  .ep_stall        (ep_stall),
  .tx_count        (tx_count),
  .buf_addr        (buf_addr),
  .status_out_pend (status_out_pend),
  .addr_we         (addr_we),
  .ctl_stage       (ctl_stage)
);

// File: tb/ep0_ctl_seq_bench.sv
module ep0_ctl_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PKT = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       setup_byte_vld = 1'b0;
  logic [7:0] setup_byte = '0;
  logic       xact_vld = 1'b0;
  logic [1:0] xact_tok = '0;
  logic [3:0] xact_len = '0;
  logic       desc_hit = 1'b0;
  logic [9:0] desc_base = '0;
  logic [15:0] desc_size = '0;
  logic       tx_arm, rx_arm, ep_stall, status_out_pend, addr_we;
  logic [3:0] tx_count;
  logic [9:0] buf_addr;
  logic [6:0] addr_val;
  logic [2:0] ctl_stage;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep0_ctl_seq u_ep0_ctl_seq (
    .clk(clk), .rst(rst), .setup_byte_vld(setup_byte_vld), .setup_byte(setup_byte),
    .xact_vld(xact_vld), .xact_tok(xact_tok), .xact_len(xact_len), .desc_hit(desc_hit),
    .desc_base(desc_base), .desc_size(desc_size), .tx_arm(tx_arm), .rx_arm(rx_arm),
    .ep_stall(ep_stall), .tx_count(tx_count), .buf_addr(buf_addr),
    .status_out_pend(status_out_pend), .addr_we(addr_we), .addr_val(addr_val),
    .ctl_stage(ctl_stage)
  );

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic xact(input int tok, input int len);
    @(negedge clk);
    xact_vld = 1'b1; xact_tok = 2'(tok); xact_len = 4'(len);
    @(posedge clk);
    @(negedge clk);
    xact_vld = 1'b0;
  endtask

  task automatic setup(input logic [7:0] t, input logic [7:0] c, input logic [15:0] v,
                       input logic [15:0] l, input logic hit, input logic [9:0] base,
                       input logic [15:0] size, input int cnt);
    logic [7:0] b [8];
    b[0] = t; b[1] = c; b[2] = v[7:0]; b[3] = v[15:8];
    b[4] = 8'h00; b[5] = 8'h00; b[6] = l[7:0]; b[7] = l[15:8];
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      setup_byte_vld = 1'b1; setup_byte = b[i];
    end
    @(negedge clk);
    setup_byte_vld = 1'b0;
    desc_hit = hit; desc_base = base; desc_size = size;
    xact_vld = 1'b1; xact_tok = 2'd2; xact_len = 4'(cnt);
    @(posedge clk);
    @(negedge clk);
    xact_vld = 1'b0;
  endtask

  int sizes [5] = '{0, 5, 8, 16, 34};

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12", "stage", ctl_stage, 0);
    chk("R12", "stall", ep_stall, 0);
    chk("R12", "pulses", {tx_arm, rx_arm, addr_we}, 0);
    chk("R12", "tx_count", tx_count, 0);
    chk("R12", "buf_addr", buf_addr, 0);

    // Control read sweep: R3 R4 R5 R6 R10
    foreach (sizes[si]) begin
      for (int l = 1; l <= 36; l++) begin
        int lim, rem, ptr, pk, base;
        base = 16 * si + l;
        lim = mn(l, sizes[si]);
        setup(8'h80, 8'h06, 16'h0100, 16'(l), 1'b1, 10'(base), 16'(sizes[si]), 8);
        chk("R3", "stage after read setup", ctl_stage, 1);
        chk("R3", "first arm", tx_arm, 1);
        chk("R10", "rx_arm after setup", rx_arm, 1);
        chk("R4", "first count", tx_count, mn(lim, PKT));
        chk("R5", "start addr", buf_addr, base);
        rem = lim; ptr = base; pk = 0;
        for (int k = 0; k < 10; k++) begin
          int cnt;
          cnt = mn(rem, PKT);
          xact(1, 0);
          pk++; rem -= cnt; ptr += cnt;
          chk("R5", "addr advance", buf_addr, ptr);
          if (rem == 0) begin
            chk("R6", "stage status-out", ctl_stage, 4);
            chk("R6", "flag set", status_out_pend, 1);
            break;
          end
          chk("R5", "next arm", tx_arm, 1);
          chk("R4", "next count", tx_count, mn(rem, PKT));
        end
        chk("R4", "packet count", pk, (lim == 0) ? 1 : (lim + PKT - 1) / PKT);
        xact(0, 0);
        chk("R6", "idle after status", ctl_stage, 0);
        chk("R6", "flag cleared", status_out_pend, 0);
        chk("R10", "rx_arm after status out", rx_arm, 1);
      end
    end

    // Control write sweep: R3 R8
    for (int l = 1; l <= 24; l++) begin
      int rem, ptr;
      setup(8'h21, 8'h09, 16'h0000, 16'(l), 1'b1, 10'(100 + l), 16'd0, 8);
      chk("R3", "stage after write setup", ctl_stage, 2);
      chk("R3", "no tx arm", tx_arm, 0);
      rem = l; ptr = 100 + l;
      while (rem > 0) begin
        int cnt;
        cnt = mn(rem, PKT);
        xact(0, cnt);
        rem -= cnt; ptr += cnt;
        chk("R8", "write addr", buf_addr, ptr);
        chk("R10", "rx rearm", rx_arm, 1);
      end
      chk("R8", "status-in stage", ctl_stage, 3);
      chk("R8", "zlp arm", tx_arm, 1);
      chk("R8", "zlp count", tx_count, 0);
      xact(1, 0);
      chk("R8", "idle", ctl_stage, 0);
      chk("R9", "no addr write", addr_we, 0);
    end

    // Short packet ends write early: R8
    setup(8'h21, 8'h09, 16'h0000, 16'd20, 1'b1, 10'd0, 16'd0, 8);
    xact(0, 8);
    chk("R8", "mid stage", ctl_stage, 2);
    xact(0, 3);
    chk("R8", "short ends", ctl_stage, 3);
    chk("R8", "short addr", buf_addr, 11);
    xact(1, 0);

    // No-data request: R2
    setup(8'h00, 8'h09, 16'h0001, 16'd0, 1'b1, 10'd0, 16'd0, 8);
    chk("R2", "stage", ctl_stage, 3);
    chk("R2", "arm", tx_arm, 1);
    chk("R2", "count", tx_count, 0);
    xact(1, 0);
    chk("R2", "idle", ctl_stage, 0);

    // Set address sweep: R1 R9
    for (int a = 0; a < 128; a += 9) begin
      setup(8'h00, 8'h05, {8'hA5, 8'(a)}, 16'd0, 1'b0, 10'd0, 16'd0, 8);
      chk("R9", "status-in", ctl_stage, 3);
      chk("R9", "not yet written", addr_we, 0);
      xact(1, 0);
      chk("R9", "strobe", addr_we, 1);
      chk("R1", "addr from value low byte", addr_val, a & 127);
      @(negedge clk);
      chk("R9", "strobe single", addr_we, 0);
    end

    // Set address with nonzero length stalls: R11 R9
    setup(8'h00, 8'h05, 16'h0033, 16'd2, 1'b1, 10'd0, 16'd0, 8);
    chk("R11", "setaddr len stall", ep_stall, 1);
    xact(1, 0);
    chk("R9", "no strobe when stalled", addr_we, 0);

    // Bad setup byte count: R1
    setup(8'h80, 8'h06, 16'h0100, 16'd8, 1'b1, 10'd0, 16'd8, 7);
    chk("R1", "short setup stall", ep_stall, 1);
    chk("R1", "stall stage", ctl_stage, 5);

    // Unsupported request: R11
    setup(8'h80, 8'h06, 16'h0100, 16'd8, 1'b0, 10'd0, 16'd8, 8);
    chk("R11", "unsupported stall", ep_stall, 1);
    xact(1, 0);
    chk("R11", "IN ignored in stall", {tx_arm, ep_stall}, 1);
    xact(0, 3);
    chk("R11", "OUT ignored in stall", ctl_stage, 5);
    chk("R10", "rx rearm in stall", rx_arm, 1);
    setup(8'h80, 8'h06, 16'h0100, 16'd4, 1'b1, 10'd0, 16'd8, 8);
    chk("R11", "setup clears stall", ep_stall, 0);
    xact(1, 0);
    // Nonzero OUT in status-out: R7
    chk("R7", "flag before", status_out_pend, 1);
    xact(0, 3);
    chk("R7", "stall", ep_stall, 1);
    chk("R7", "flag cleared", status_out_pend, 0);

    // Unexpected IN in idle: R11
    setup(8'h00, 8'h09, 16'h0001, 16'd0, 1'b1, 10'd0, 16'd0, 8);
    xact(1, 0);
    xact(1, 0);
    chk("R11", "IN in idle", ep_stall, 1);

    // Over-long OUT: R11
    setup(8'h21, 8'h09, 16'h0000, 16'd5, 1'b1, 10'd0, 16'd0, 8);
    xact(0, 6);
    chk("R11", "OUT over remaining", ep_stall, 1);
    chk("R11", "addr unchanged", buf_addr, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule